// File: doc/BRIEF.md
# Transmit Descriptor Ring Sequencer

This block moves frames from host memory to a transmit byte stream under control of a descriptor ring. Host software keeps a ring of 16-byte descriptors in memory, each naming a buffer address and a frame length, and advances a head index through a write port when it has posted new entries. The block follows the ring one entry at a time. It first reads a descriptor through a tagged DMA-read request port, then reads the frame buffer named by that descriptor, streams the returned bytes out as a frame, and finally asks a completion writer to log the finished entry.

Two indices run inside the block. The fetch index counts descriptors whose read has been issued, and it is the tag carried by both reads of an entry. The commit (tail) index counts frames fully sent, and it is visible on a port so a register file can expose it. Only one entry is in flight, so completions leave in ring order. Read responses come back as a byte stream tagged with the request's tag. Bytes whose tag does not belong to the outstanding request are accepted and thrown away.

Top module: `tx_ring_sequencer`

## Requirements
- R1: After reset the read request, frame stream and completion outputs are all idle and the tail index is 0.
- R2: No descriptor read is requested while the posted head index equals the fetch index.
- R3: A descriptor read requests 16 bytes at ring_base + (fetch index AND (2^ring_size_log2 - 1)) * 16, with kind 0 and the fetch index as tag; it holds its fields stable until accepted.
- R4: The descriptor bytes arrive in address order; bytes 0..7 form the buffer address and bytes 8..11 the frame length, both least significant byte first, bytes 12..15 are ignored. The data read that follows requests that address and length, with kind 1 and the same tag.
- R5: Data bytes with the outstanding tag leave on the frame stream in order, tx_last marks the byte at offset length-1, and a byte that is not taken stays presented unchanged.
- R6: The tail index rises by exactly one in the cycle after the last byte of a frame is accepted, and at no other time.
- R7: After the tail commit a completion request carries tag = the committed entry's index, the frame length, and cpl_is_tx = 1, and it holds until accepted.
- R8: The next descriptor read is not requested before the previous entry's completion is accepted.
- R9: A response byte whose tag differs from the outstanding request, or that arrives when no response is awaited, is consumed (rsp_ready = 1) and affects neither the frame stream nor the tail index.
- R10: The ring slot wraps: entry index 4 with ring_size_log2 = 2 is read from ring_base itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hd_we | input | 1 | Head index write strobe |
| hd_wdata | input | PTR_W | New head index |
| ring_base | input | ADDR_W | Byte address of ring slot 0 |
| ring_size_log2 | input | LOG2_W | Ring holds 2^ring_size_log2 slots |
| tail_ptr | output | PTR_W | Committed tail index |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | ADDR_W | Read byte address |
| rd_len | output | LEN_W | Read length in bytes |
| rd_tag | output | PTR_W | Read tag |
| rd_kind | output | 1 | 0 descriptor read, 1 frame data read |
| rsp_valid | input | 1 | Response byte valid |
| rsp_ready | output | 1 | Response byte taken |
| rsp_data | input | 8 | Response byte |
| rsp_tag | input | PTR_W | Tag of the response byte |
| tx_valid | output | 1 | Frame byte valid |
| tx_ready | input | 1 | Frame byte taken |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| cpl_valid | output | 1 | Completion request valid |
| cpl_ready | input | 1 | Completion request taken |
| cpl_tag | output | PTR_W | Ring index of the completed entry |
| cpl_len | output | LEN_W | Frame length of the completed entry |
| cpl_is_tx | output | 1 | Transmit completion flag |

## Verification
The hardest situation to reach from the ports is a stray response byte whose tag belongs to no outstanding request, together with a frame byte held under stream backpressure while the responder keeps it presented. The bench's memory responder can push response bytes with an arbitrary tag into its own queue while the block is idle, and it randomly stalls the response, frame and completion handshakes so bytes sit presented across several cycles. Posting more entries than the ring holds in total drives the fetch index past the ring size, so slot wrap is reached with a small ring.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int DESC_BYTES   = 16;
  localparam int DESC_SHIFT   = 4;
  localparam int DESC_KEEP    = 12;
  localparam int DESC_LEN_BIT = 64;
  localparam logic KIND_DESC  = 1'b0;
  localparam logic KIND_DATA  = 1'b1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DESC_REQ,
    ST_DESC_RSP,
    ST_DATA_REQ,
    ST_DATA_RSP,
    ST_CPL
  } txr_state_e;
endpackage

// File: rtl/txr_ptr_unit.sv
module txr_ptr_unit #(
  parameter int PTR_W  = 16,
  parameter int ADDR_W = 64,
  parameter int LOG2_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_we,
  input  logic [PTR_W-1:0]  head_wdata,
  input  logic              fetch_adv,
  input  logic              commit_adv,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [LOG2_W-1:0] ring_size_log2,
  output logic [PTR_W-1:0]  fetch_ptr,
  output logic [PTR_W-1:0]  tail_ptr,
  output logic              ring_empty,
  output logic [ADDR_W-1:0] slot_addr
);
  import txr_pkg::*;

  logic [PTR_W-1:0] head_q, fetch_q, tail_q;

  function automatic logic [ADDR_W-1:0] slot_offset(input logic [PTR_W-1:0] idx,
                                                    input logic [LOG2_W-1:0] lg);
    logic [PTR_W:0]   span;
    logic [PTR_W-1:0] mask;
    span = {{PTR_W{1'b0}}, 1'b1} << lg;
    mask = span[PTR_W-1:0] - {{(PTR_W-1){1'b0}}, 1'b1};
    return ADDR_W'(idx & mask) << DESC_SHIFT;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      fetch_q <= '0;
      tail_q  <= '0;
    end else begin
      if (head_we)    head_q  <= head_wdata;
      if (fetch_adv)  fetch_q <= fetch_q + 1'b1;
      if (commit_adv) tail_q  <= tail_q + 1'b1;
    end
  end

  assign fetch_ptr  = fetch_q;
  assign tail_ptr   = tail_q;
  assign ring_empty = (head_q == fetch_q);
  assign slot_addr  = ring_base + slot_offset(fetch_q, ring_size_log2);

  // R6: the tail only ever steps by one
  p_tail_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tail_q) |-> tail_q == $past(tail_q) + 1'b1);

  // R8: fetch never runs more than one entry ahead of the commit index
  p_one_inflight_r8: assert property (@(posedge clk) disable iff (!rst_n)
    PTR_W'(fetch_q - tail_q) <= PTR_W'(1));
endmodule

// File: rtl/txr_desc_capture.sv
module txr_desc_capture #(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  output logic              done,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [LEN_W-1:0]  buf_len
);
  import txr_pkg::*;

  localparam int CNT_W  = $clog2(DESC_BYTES + 1);
  localparam int KEEP_W = DESC_KEEP * 8;

  logic [CNT_W-1:0]  cnt_q;
  logic [KEEP_W-1:0] shreg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      shreg_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (byte_valid && !done) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q < CNT_W'(DESC_KEEP))
        shreg_q <= {byte_data, shreg_q[KEEP_W-1:8]};
    end
  end

  assign done     = (cnt_q == CNT_W'(DESC_BYTES));
  assign buf_addr = shreg_q[ADDR_W-1:0];
  assign buf_len  = shreg_q[DESC_LEN_BIT +: LEN_W];

  // R4: the byte counter never passes the descriptor size
  p_desc_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done || $past(clear)));
endmodule

// File: rtl/tx_ring_sequencer.sv
module tx_ring_sequencer #(
  parameter int ADDR_W = 64,
  parameter int PTR_W  = 16,
  parameter int LEN_W  = 32,
  parameter int LOG2_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hd_we,
  input  logic [PTR_W-1:0]  hd_wdata,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [LOG2_W-1:0] ring_size_log2,
  output logic [PTR_W-1:0]  tail_ptr,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [LEN_W-1:0]  rd_len,
  output logic [PTR_W-1:0]  rd_tag,
  output logic              rd_kind,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [7:0]        rsp_data,
  input  logic [PTR_W-1:0]  rsp_tag,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic              cpl_valid,
  input  logic              cpl_ready,
  output logic [PTR_W-1:0]  cpl_tag,
  output logic [LEN_W-1:0]  cpl_len,
  output logic              cpl_is_tx
);
  import txr_pkg::*;

  txr_state_e        state_q;
  logic [PTR_W-1:0]  cur_tag_q;
  logic [LEN_W-1:0]  byte_cnt_q;

  logic [PTR_W-1:0]  fetch_ptr;
  logic              ring_empty;
  logic [ADDR_W-1:0] slot_addr;
  logic              desc_done;
  logic [ADDR_W-1:0] buf_addr;
  logic [LEN_W-1:0]  buf_len;

  // named internal events
  logic tag_hit, desc_issue, data_issue, desc_byte, beat, frame_done, cpl_take;

  assign tag_hit    = (rsp_tag == cur_tag_q);
  assign desc_issue = (state_q == ST_DESC_REQ) && rd_ready;
  assign data_issue = (state_q == ST_DATA_REQ) && rd_ready;
  assign desc_byte  = (state_q == ST_DESC_RSP) && rsp_valid && tag_hit && !desc_done;
  assign beat       = tx_valid && tx_ready;
  assign frame_done = beat && tx_last;
  assign cpl_take   = (state_q == ST_CPL) && cpl_ready;

  txr_ptr_unit #(.PTR_W(PTR_W), .ADDR_W(ADDR_W), .LOG2_W(LOG2_W)) u_ptr (
    .clk            (clk),
    .rst_n          (rst_n),
    .head_we        (hd_we),
    .head_wdata     (hd_wdata),
    .fetch_adv      (desc_issue),
    .commit_adv     (frame_done),
    .ring_base      (ring_base),
    .ring_size_log2 (ring_size_log2),
    .fetch_ptr      (fetch_ptr),
    .tail_ptr       (tail_ptr),
    .ring_empty     (ring_empty),
    .slot_addr      (slot_addr)
  );

  txr_desc_capture #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_desc (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (desc_issue),
    .byte_valid (desc_byte),
    .byte_data  (rsp_data),
    .done       (desc_done),
    .buf_addr   (buf_addr),
    .buf_len    (buf_len)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cur_tag_q  <= '0;
      byte_cnt_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE:     if (!ring_empty) state_q <= ST_DESC_REQ;
        ST_DESC_REQ: if (desc_issue) begin
                       cur_tag_q <= fetch_ptr;
                       state_q   <= ST_DESC_RSP;
                     end
        ST_DESC_RSP: if (desc_done) state_q <= ST_DATA_REQ;
        ST_DATA_REQ: if (data_issue) begin
                       byte_cnt_q <= '0;
                       state_q    <= ST_DATA_RSP;
                     end
        ST_DATA_RSP: if (beat) begin
                       byte_cnt_q <= byte_cnt_q + 1'b1;
                       if (tx_last) state_q <= ST_CPL;
                     end
        ST_CPL:      if (cpl_take) state_q <= ST_IDLE;
        default:     state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_valid = 1'b0;
    rd_addr  = slot_addr;
    rd_len   = LEN_W'(DESC_BYTES);
    rd_tag   = fetch_ptr;
    rd_kind  = KIND_DESC;
    if (state_q == ST_DESC_REQ) begin
      rd_valid = 1'b1;
    end else if (state_q == ST_DATA_REQ) begin
      rd_valid = 1'b1;
      rd_addr  = buf_addr;
      rd_len   = buf_len;
      rd_tag   = cur_tag_q;
      rd_kind  = KIND_DATA;
    end
  end

  assign rsp_ready = (state_q == ST_DATA_RSP && tag_hit) ? tx_ready : 1'b1;
  assign tx_valid  = (state_q == ST_DATA_RSP) && rsp_valid && tag_hit;
  assign tx_data   = rsp_data;
  assign tx_last   = (byte_cnt_q == buf_len - 1'b1);
  assign cpl_valid = (state_q == ST_CPL);
  assign cpl_tag   = cur_tag_q;
  assign cpl_len   = buf_len;
  assign cpl_is_tx = 1'b1;

  // R2: a descriptor read never starts from an empty ring
  p_no_read_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_kind == KIND_DESC) |-> !ring_empty);

  // R3: an unaccepted request keeps its fields
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr) && $stable(rd_tag) && $stable(rd_kind)));

  // R7: the completion names the entry just committed and waits for acceptance
  p_cpl_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> (cpl_tag == tail_ptr - 1'b1));
  p_cpl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_ready) |=> (cpl_valid && $stable(cpl_tag) && $stable(cpl_len)));

  // R9: only bytes of the entry at the commit index reach the frame stream
  p_data_tag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (rsp_tag == tail_ptr));
endmodule

// File: tb/tx_ring_sequencer_bench.sv
module tx_ring_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 64;
  localparam int PTR_W  = 16;
  localparam int LEN_W  = 32;
  localparam int LOG2_W = 5;
  localparam int SIZE_LOG2 = 2;
  localparam longint unsigned BASE = 64'h0000_0001_0000_1000;

  typedef struct {
    longint unsigned addr;
    int unsigned     len;
    int unsigned     tag;
    bit              kind;
  } req_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hd_we = 1'b0;
  logic [PTR_W-1:0] hd_wdata = '0;
  logic [PTR_W-1:0] tail_ptr;
  logic rd_valid, rd_ready = 1'b1;
  logic [ADDR_W-1:0] rd_addr;
  logic [LEN_W-1:0] rd_len;
  logic [PTR_W-1:0] rd_tag;
  logic rd_kind;
  logic rsp_valid = 1'b0, rsp_ready;
  logic [7:0] rsp_data = '0;
  logic [PTR_W-1:0] rsp_tag = '0;
  logic tx_valid, tx_ready = 1'b1, tx_last;
  logic [7:0] tx_data;
  logic cpl_valid, cpl_ready = 1'b1, cpl_is_tx;
  logic [PTR_W-1:0] cpl_tag;
  logic [LEN_W-1:0] cpl_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_ring_sequencer #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .LEN_W(LEN_W), .LOG2_W(LOG2_W))
  u_tx_ring_sequencer (
    .clk(clk), .rst_n(rst_n), .hd_we(hd_we), .hd_wdata(hd_wdata),
    .ring_base(BASE), .ring_size_log2(LOG2_W'(SIZE_LOG2)), .tail_ptr(tail_ptr),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_len(rd_len),
    .rd_tag(rd_tag), .rd_kind(rd_kind), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_tag(rsp_tag), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
    .cpl_tag(cpl_tag), .cpl_len(cpl_len), .cpl_is_tx(cpl_is_tx)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit running = 1'b0;
  bit stall_en = 1'b0;

  logic [7:0] mem [longint unsigned];
  req_t exp_rd[$];
  req_t rsp_q[$];
  int unsigned rsp_idx = 0;
  logic [7:0] exp_tx[$];
  bit exp_last[$];
  int unsigned exp_cpl_tag[$];
  int unsigned exp_cpl_len[$];

  int unsigned head_model = 0;
  int unsigned tail_model = 0;
  int unsigned desc_reqs = 0;
  int unsigned cpl_done = 0;
  int unsigned rd_seen = 0;
  int unsigned tx_seen = 0;
  bit tx_held = 1'b0;
  logic [7:0] tx_held_data;

  task automatic chk(input bit ok, input string req, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s", req, what);
    end
  endtask

  function automatic logic [7:0] rd_mem(input longint unsigned a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // per-clock monitor and responder
  always @(negedge clk) begin
    if (running) begin
      // R6: tail equals the number of frames whose last byte was taken
      chk(tail_ptr == PTR_W'(tail_model), "R6",
          $sformatf("tail act=%0d exp=%0d", tail_ptr, tail_model));
      if (tx_held)
        chk(tx_valid && tx_data == tx_held_data, "R5",
            $sformatf("held byte act=%0h/%0b exp=%0h/1", tx_data, tx_valid, tx_held_data));
      // drive responder
      if (!(rsp_valid && !rsp_ready)) begin
        if (rsp_q.size() > 0 && (!stall_en || ($urandom % 4) != 0)) begin
          rsp_valid = 1'b1;
          rsp_data  = rd_mem(rsp_q[0].addr + rsp_idx);
          rsp_tag   = PTR_W'(rsp_q[0].tag);
        end else begin
          rsp_valid = 1'b0;
        end
      end
      rd_ready  = !stall_en || ($urandom % 3) != 0;
      tx_ready  = !stall_en || ($urandom % 3) != 0;
      cpl_ready = !stall_en || ($urandom % 2) != 0;
      #1;
      if (rd_valid && rd_ready) begin
        rd_seen++;
        if (exp_rd.size() == 0) begin
          chk(1'b0, "R2", $sformatf("unexpected read addr=%0h act=issued exp=none", rd_addr));
        end else begin
          req_t e;
          e = exp_rd.pop_front();
          if (!rd_kind) begin
            chk(desc_reqs == cpl_done, "R8",
                $sformatf("outstanding act=%0d exp=0", desc_reqs - cpl_done));
            desc_reqs++;
          end
          chk(rd_addr == e.addr && rd_len == e.len && rd_tag == PTR_W'(e.tag) && rd_kind == e.kind,
              e.kind ? "R4" : (e.tag >= (1 << SIZE_LOG2) ? "R10" : "R3"),
              $sformatf("req act=%0h/%0d/%0d/%0b exp=%0h/%0d/%0d/%0b",
                        rd_addr, rd_len, rd_tag, rd_kind, e.addr, e.len, e.tag, e.kind));
          rsp_q.push_back('{addr: rd_addr, len: rd_len, tag: rd_tag, kind: rd_kind});
        end
      end
      if (rsp_valid && rsp_ready) begin
        rsp_idx++;
        if (rsp_idx == rsp_q[0].len) begin
          void'(rsp_q.pop_front());
          rsp_idx = 0;
        end
      end
      tx_held = tx_valid && !tx_ready;
      tx_held_data = tx_data;
      if (tx_valid && tx_ready) begin
        tx_seen++;
        if (exp_tx.size() == 0) begin
          chk(1'b0, "R9", $sformatf("unexpected byte act=%0h exp=none", tx_data));
        end else begin
          logic [7:0] eb;
          bit el;
          eb = exp_tx.pop_front();
          el = exp_last.pop_front();
          chk(tx_data == eb && tx_last == el, "R5",
              $sformatf("byte act=%0h/%0b exp=%0h/%0b", tx_data, tx_last, eb, el));
          if (tx_last) tail_model++;
        end
      end
      if (cpl_valid && cpl_ready) begin
        if (exp_cpl_tag.size() == 0) begin
          chk(1'b0, "R7", "unexpected completion act=issued exp=none");
        end else begin
          int unsigned et, el2;
          et = exp_cpl_tag.pop_front();
          el2 = exp_cpl_len.pop_front();
          chk(cpl_tag == PTR_W'(et) && cpl_len == el2 && cpl_is_tx && tail_ptr == PTR_W'(et + 1), "R7",
              $sformatf("cpl act=%0d/%0d/%0b tail=%0d exp=%0d/%0d/1 tail=%0d",
                        cpl_tag, cpl_len, cpl_is_tx, tail_ptr, et, el2, et + 1));
          cpl_done++;
        end
      end
    end
  end

  task automatic post_frame(input int unsigned len, input longint unsigned bufa);
    int unsigned slot;
    longint unsigned da;
    slot = head_model & ((1 << SIZE_LOG2) - 1);
    da = BASE + slot * 16;
    for (int i = 0; i < 8; i++) mem[da + i] = 8'(bufa >> (8 * i));
    for (int i = 0; i < 4; i++) mem[da + 8 + i] = 8'(len >> (8 * i));
    for (int i = 12; i < 16; i++) mem[da + i] = 8'hA5;
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      mem[bufa + i] = b;
      exp_tx.push_back(b);
      exp_last.push_back(i == len - 1);
    end
    exp_rd.push_back('{addr: da, len: 16, tag: head_model, kind: 1'b0});
    exp_rd.push_back('{addr: bufa, len: len, tag: head_model, kind: 1'b1});
    exp_cpl_tag.push_back(head_model);
    exp_cpl_len.push_back(len);
    head_model = (head_model + 1) & 16'hFFFF;
    @(negedge clk);
    hd_we = 1'b1;
    hd_wdata = PTR_W'(head_model);
    @(negedge clk);
    hd_we = 1'b0;
  endtask

  task automatic drain();
    while (exp_cpl_tag.size() > 0) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    chk(1'b0, "R1", "watchdog act=running exp=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!rd_valid && !tx_valid && !cpl_valid && tail_ptr == 0, "R1",
        $sformatf("reset act=%0b%0b%0b/%0d exp=000/0", rd_valid, tx_valid, cpl_valid, tail_ptr));
    @(negedge clk);
    rst_n = 1'b1;
    running = 1'b1;
    // R2: empty ring stays quiet
    repeat (20) @(negedge clk);
    chk(rd_seen == 0 && !rd_valid, "R2", $sformatf("idle reads act=%0d exp=0", rd_seen));
    // single-byte frame, no stalls
    post_frame(1, 64'h0000_0002_0000_0000);
    drain();
    // several frames under backpressure
    stall_en = 1'b1;
    post_frame(5, 64'h0000_0002_0000_0100);
    post_frame(17, 64'h0000_0002_0000_0200);
    post_frame(2, 64'h0000_0002_0000_0300);
    drain();
    // R9: stray response with a foreign tag while idle
    begin
      int unsigned tx_before;
      tx_before = tx_seen;
      rsp_q.push_back('{addr: 64'h9000, len: 5, tag: 16'h0077, kind: 1'b0});
      while (rsp_q.size() > 0) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(tx_seen == tx_before && tail_ptr == PTR_W'(tail_model), "R9",
          $sformatf("stray act=%0d bytes tail=%0d exp=0 bytes tail=%0d",
                    tx_seen - tx_before, tail_ptr, tail_model));
    end
    // R10: wrap past the ring size
    post_frame(3, 64'h0000_0002_0000_0400);
    post_frame(9, 64'h0000_0002_0000_0500);
    post_frame(4, 64'h0000_0002_0000_0600);
    drain();
    chk(exp_tx.size() == 0 && exp_rd.size() == 0, "R5",
        $sformatf("leftover act=%0d/%0d exp=0/0", exp_tx.size(), exp_rd.size()));
    chk(tail_ptr == 7, "R10", $sformatf("final tail act=%0d exp=7", tail_ptr));
    running = 1'b0;
    summary();
  end
endmodule